// File: doc/BRIEF.md
# Paged Address Translator with Status

This block turns a logical address in the low 4 MB region into a physical address by looking up a 16-bit descriptor per 4 KB page in a 1024-entry table held inside the block. The logical page number indexes the table. The physical page number stored in the descriptor replaces it, and the byte offset inside the page is kept. Addresses at 4 MB and above are not translated: the block hands them on as they are and touches no descriptor.

Each descriptor also records how its page has been used. A two-bit usage field tracks four states: absent, mapped but untouched, read, and written. Every translated access updates this field in place, at the same clock edge that completes the access. An access to an absent page is reported on a not-present output and leaves the descriptor as it was. The descriptor's write-enable bit and its page number are never changed by these updates.

Software reaches the table through a byte-addressed port. It can do word or single-byte writes and has a combinational read. Each descriptor occupies two bytes, with the high byte at the even address. The table repeats every 2 KB across the port's address window. When a port write and a usage update hit the same descriptor in the same cycle, the port write wins.

Top module: `pat_translator`

## Requirements
- R1: An access whose address is 0x400000 or higher gives `phys_addr` equal to `acc_addr` and `not_present` low, and it leaves every descriptor unchanged.
- R2: An access below 0x400000 uses address bits 21:12 as the descriptor index. `phys_addr` is then zero above bit 21, holds descriptor bits 9:0 in bits 21:12, and keeps the offset bits 11:0 of the address. The output is combinational in the same cycle.
- R3: `not_present` is high exactly when `acc_valid` is high, the address is below 0x400000, and the indexed descriptor has usage field (bits 14:13) equal to 0. Such an access changes nothing.
- R4: A valid access to a descriptor with usage field 1 sets the field to 3 for a write and to 2 for a read.
- R5: A valid access to a descriptor with usage field 2 or 3 sets the field to 3 for a write. For a read the field stays as it was.
- R6: A usage update leaves the write-enable bit 15 and bits 12:0 of the descriptor unchanged.
- R7: A port word write (`cpu_word` high) stores `cpu_wdata` in descriptor `cpu_addr[10:1]`. The new value is visible on `cpu_rdata` in the cycle after the write, and `cpu_rdata` always shows the descriptor that `cpu_addr` selects.
- R8: A port byte write (`cpu_word` low) takes `cpu_wdata[7:0]`. At an even `cpu_addr` it replaces descriptor bits 15:8, and at an odd `cpu_addr` it replaces bits 7:0. The other byte is kept.
- R9: `cpu_addr` bits above bit 10 are ignored, so the table repeats every 2 KB of port addresses.
- R10: When a port write and a usage update target the same descriptor in one cycle, the descriptor afterwards holds the port's data.
- R11: Reset clears every descriptor to 0.
- R12: When `acc_valid` is low, no descriptor changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | ADDR_W (24) | Logical address |
| phys_addr | output | ADDR_W (24) | Physical address |
| not_present | output | 1 | Access hit an absent page |
| cpu_wr | input | 1 | Port write strobe |
| cpu_word | input | 1 | Port write is a 16-bit word (else a byte) |
| cpu_addr | input | CPU_AW (16) | Port byte address |
| cpu_wdata | input | 16 | Port write data (byte writes use bits 7:0) |
| cpu_rdata | output | 16 | Descriptor selected by `cpu_addr` |

## Verification
The physical address and the not-present flag are combinational, so they are due in the same cycle as the access. The bench drives inputs on the falling edge and samples these outputs 1 ns later, before the next rising edge. Usage updates and port writes take effect at the next rising edge, so the bench reads them back on `cpu_rdata` after the following falling edge, with no other write in between. A sweep over all 1024 descriptors covers every usage state, both access kinds and both write-enable values. The pass-through, byte lane, mirror, collision and idle cases each get a read-back that follows the same schedule.

// File: rtl/pat_pkg.sv
`timescale 1ns/1ps
package pat_pkg;
   localparam int unsigned ENTRY_W = 16;
   localparam int unsigned WE_BIT  = 15;
   localparam int unsigned ST_LO   = 13;
   localparam int unsigned ST_HI   = 14;

   typedef enum logic [1:0] {
      PG_ABSENT = 2'd0,
      PG_FRESH  = 2'd1,
      PG_READ   = 2'd2,
      PG_DIRTY  = 2'd3
   } pg_state_e;

   // usage transition for one translated access
   function automatic pg_state_e pg_advance(pg_state_e s, logic wr);
      case (s)
         PG_ABSENT: return PG_ABSENT;
         PG_FRESH:  return wr ? PG_DIRTY : PG_READ;
         default:   return wr ? PG_DIRTY : s;
      endcase
   endfunction
endpackage

// File: rtl/pat_addr_path.sv
`timescale 1ns/1ps
module pat_addr_path #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned PAGE_W = 10,
   parameter int unsigned OFFS_W = 12
) (
   input  logic [ADDR_W-1:0]           acc_addr,
   input  logic [pat_pkg::ENTRY_W-1:0] entry,
   output logic                        in_ram,
   output logic [PAGE_W-1:0]           vpn,
   output logic [ADDR_W-1:0]           phys
);
   localparam int unsigned RAM_W = PAGE_W + OFFS_W;
   localparam int unsigned PAD_W = ADDR_W - RAM_W;

   always_comb begin
      in_ram = (acc_addr[ADDR_W-1:RAM_W] == '0);
      vpn    = acc_addr[RAM_W-1:OFFS_W];
      if (in_ram)
         phys = {{PAD_W{1'b0}}, entry[PAGE_W-1:0], acc_addr[OFFS_W-1:0]};
      else
         phys = acc_addr;
   end
endmodule

// File: rtl/pat_status_next.sv
`timescale 1ns/1ps
module pat_status_next
   import pat_pkg::*;
(
   input  logic [ENTRY_W-1:0] entry,
   input  logic               wr,
   output pg_state_e          cur_st,
   output logic [ENTRY_W-1:0] new_entry
);
   pg_state_e nxt;

   always_comb begin
      cur_st    = pg_state_e'(entry[ST_HI:ST_LO]);
      nxt       = pg_advance(cur_st, wr);
      new_entry = entry;
      new_entry[ST_HI:ST_LO] = nxt;
   end
endmodule

// File: rtl/pat_map_store.sv
`timescale 1ns/1ps
module pat_map_store #(
   parameter int unsigned PAGE_W         = 10,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [PAGE_W-1:0]           rd_idx,
   output logic [pat_pkg::ENTRY_W-1:0] rd_data,
   input  logic [PAGE_W-1:0]           cpu_idx,
   output logic [pat_pkg::ENTRY_W-1:0] cpu_rdata,
   input  logic                        cpu_wr,
   input  logic [1:0]                  cpu_ben,
   input  logic [pat_pkg::ENTRY_W-1:0] cpu_wdata,
   input  logic                        st_wr,
   input  logic [PAGE_W-1:0]           st_idx,
   input  logic [pat_pkg::ENTRY_W-1:0] st_data
);
   localparam int unsigned ENTRIES = 1 << PAGE_W;

   logic [pat_pkg::ENTRY_W-1:0] tbl [ENTRIES];
   logic st_keep;

   assign rd_data   = tbl[rd_idx];
   assign cpu_rdata = tbl[cpu_idx];
   // a port write to the same descriptor suppresses the usage update
   assign st_keep   = st_wr && !(cpu_wr && (cpu_idx == st_idx));

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int k = 0; k < ENTRIES; k++) tbl[k] <= '0;
            end else begin
               if (st_keep) tbl[st_idx] <= st_data;
               if (cpu_wr && cpu_ben[1]) tbl[cpu_idx][15:8] <= cpu_wdata[15:8];
               if (cpu_wr && cpu_ben[0]) tbl[cpu_idx][7:0]  <= cpu_wdata[7:0];
            end
         end
      end else begin : g_noclr
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (st_keep) tbl[st_idx] <= st_data;
            if (cpu_wr && cpu_ben[1]) tbl[cpu_idx][15:8] <= cpu_wdata[15:8];
            if (cpu_wr && cpu_ben[0]) tbl[cpu_idx][7:0]  <= cpu_wdata[7:0];
         end
      end
   endgenerate
endmodule

// File: rtl/pat_translator.sv
`timescale 1ns/1ps
module pat_translator
   import pat_pkg::*;
#(
   parameter int unsigned ADDR_W         = 24,
   parameter int unsigned PAGE_W         = 10,
   parameter int unsigned OFFS_W         = 12,
   parameter int unsigned CPU_AW         = 16,
   parameter bit          CLEAR_ON_RESET = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   output logic [ADDR_W-1:0]  phys_addr,
   output logic               not_present,
   input  logic               cpu_wr,
   input  logic               cpu_word,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [15:0]        cpu_wdata,
   output logic [15:0]        cpu_rdata
);
   localparam int unsigned IDX_HI = PAGE_W;

   generate
      if (ADDR_W <= PAGE_W + OFFS_W) begin : g_bad_aw
         $error("ADDR_W must exceed PAGE_W + OFFS_W");
      end
      if (PAGE_W > ST_LO) begin : g_bad_pw
         $error("PAGE_W overlaps the usage field");
      end
      if (CPU_AW <= PAGE_W + 1) begin : g_bad_cw
         $error("CPU_AW must exceed PAGE_W + 1");
      end
   endgenerate

   logic              in_ram;
   logic [PAGE_W-1:0] vpn;
   logic [ENTRY_W-1:0] cur_entry;
   logic [ENTRY_W-1:0] st_data;
   pg_state_e         cur_st;
   logic              st_wr;
   logic [PAGE_W-1:0] cpu_idx;
   logic [1:0]        cpu_ben;
   logic [15:0]       cpu_wd;
   logic              unused_hi;

   assign cpu_idx   = cpu_addr[IDX_HI:1];
   assign unused_hi = ^cpu_addr[CPU_AW-1:IDX_HI+1];
   assign cpu_ben   = cpu_word ? 2'b11 : (cpu_addr[0] ? 2'b01 : 2'b10);
   assign cpu_wd    = cpu_word ? cpu_wdata : {2{cpu_wdata[7:0]}};

   pat_addr_path #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFFS_W(OFFS_W)) u_path (
      .acc_addr (acc_addr),
      .entry    (cur_entry),
      .in_ram   (in_ram),
      .vpn      (vpn),
      .phys     (phys_addr)
   );

   pat_status_next u_next (
      .entry     (cur_entry),
      .wr        (acc_write),
      .cur_st    (cur_st),
      .new_entry (st_data)
   );

   assign st_wr       = acc_valid && in_ram && (cur_st != PG_ABSENT);
   assign not_present = acc_valid && in_ram && (cur_st == PG_ABSENT);

   pat_map_store #(.PAGE_W(PAGE_W), .CLEAR_ON_RESET(CLEAR_ON_RESET)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (vpn),
      .rd_data   (cur_entry),
      .cpu_idx   (cpu_idx),
      .cpu_rdata (cpu_rdata),
      .cpu_wr    (cpu_wr),
      .cpu_ben   (cpu_ben),
      .cpu_wdata (cpu_wd),
      .st_wr     (st_wr),
      .st_idx    (vpn),
      .st_data   (st_data)
   );
endmodule

// File: rtl/pat_translator_chk.sv
`timescale 1ns/1ps
module pat_translator_chk #(
   parameter int unsigned ADDR_W = 24,
   parameter int unsigned PAGE_W = 10,
   parameter int unsigned OFFS_W = 12,
   parameter int unsigned CPU_AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [ADDR_W-1:0] phys_addr,
   input logic              not_present,
   input logic              cpu_wr,
   input logic              cpu_word,
   input logic [CPU_AW-1:0] cpu_addr,
   input logic [15:0]       cpu_wdata,
   input logic [15:0]       cpu_rdata,
   input logic [15:0]       cur_entry,
   input logic              st_wr,
   input logic [15:0]       st_data
);
   localparam int unsigned RAM_W = PAGE_W + OFFS_W;

   logic hi_zone;
   assign hi_zone = (acc_addr[ADDR_W-1:RAM_W] != '0);

   // R1
   pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && hi_zone) |-> (phys_addr == acc_addr && !not_present));

   // R3
   absent_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      not_present |-> (acc_valid && !hi_zone && cur_entry[14:13] == 2'd0 && !st_wr));

   // R4
   fresh_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && !acc_write && cur_entry[14:13] == 2'd1) |-> (st_data[14:13] == 2'd2));

   // R5
   write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_wr && acc_write) |-> (st_data[14:13] == 2'd3));

   // R6
   keep_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_wr |-> (st_data[15] == cur_entry[15] && st_data[12:0] == cur_entry[12:0]));

   // R10
   cpu_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_word) |=>
         ((cpu_addr[PAGE_W:1] != $past(cpu_addr[PAGE_W:1])) || (cpu_rdata == $past(cpu_wdata))));

   // R12
   idle_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |-> !st_wr);
endmodule

bind pat_translator pat_translator_chk #(
   .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFFS_W(OFFS_W), .CPU_AW(CPU_AW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .acc_valid   (acc_valid),
   .acc_write   (acc_write),
   .acc_addr    (acc_addr),
   .phys_addr   (phys_addr),
   .not_present (not_present),
   .cpu_wr      (cpu_wr),
   .cpu_word    (cpu_word),
   .cpu_addr    (cpu_addr),
   .cpu_wdata   (cpu_wdata),
   .cpu_rdata   (cpu_rdata),
   .cur_entry   (cur_entry),
   .st_wr       (st_wr),
   .st_data     (st_data)
);

// File: tb/tb_pat_translator.sv
`timescale 1ns/1ps
module tb_pat_translator;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_valid = 1'b0;
   logic        acc_write = 1'b0;
   logic [23:0] acc_addr = '0;
   logic [23:0] phys_addr;
   logic        not_present;
   logic        cpu_wr = 1'b0;
   logic        cpu_word = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;

   int vectors = 0;
   int miscompares = 0;

   always #2 clk = ~clk;

   pat_translator dut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .phys_addr(phys_addr), .not_present(not_present),
      .cpu_wr(cpu_wr), .cpu_word(cpu_word), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] sw_entry(int i);
      logic [9:0] ppn;
      logic [2:0] b;
      ppn = 10'((i * 37 + 5) % 1024);
      b   = 3'(i);
      return {b[0], b[2:1], 3'b000, ppn};
   endfunction

   function automatic logic [15:0] sw_after(int i);
      logic [15:0] e;
      logic [1:0]  s;
      logic [3:0]  b;
      e = sw_entry(i);
      s = e[14:13];
      b = 4'(i);
      if (s == 2'd1) s = b[3] ? 2'd3 : 2'd2;
      else if (s != 2'd0 && b[3]) s = 2'd3;
      e[14:13] = s;
      return e;
   endfunction

   task automatic cpu_put(input logic [15:0] a, input logic word, input logic [15:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_word = word; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic peek(input logic [15:0] a, output logic [15:0] v);
      cpu_addr = a;
      #1;
      v = cpu_rdata;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R11: cleared table after reset
      peek(16'h0000, v); chk("R11 entry0", 32'(v), 32'h0);
      peek(16'h07FE, v); chk("R11 entry1023", 32'(v), 32'h0);
      peek(16'h0400, v); chk("R11 entry512", 32'(v), 32'h0);
      // R3: absent page flagged
      acc_valid = 1'b1; acc_addr = 24'h000123; #1;
      chk("R3 absent after reset", 32'(not_present), 32'h1);
      chk("R2 phys after reset", 32'(phys_addr), 32'h000123);
      @(negedge clk); acc_valid = 1'b0;
      peek(16'h0000, v); chk("R3 absent unchanged", 32'(v), 32'h0);

      // R7: load every descriptor by word writes
      for (int i = 0; i < 1024; i++) cpu_put(16'(i * 2), 1'b1, sw_entry(i));
      for (int i = 0; i < 1024; i += 97) begin
         peek(16'(i * 2), v); chk("R7 readback", 32'(v), 32'(sw_entry(i)));
      end

      // R2 R3 R4 R5 R6: sweep all pages
      for (int i = 0; i < 1024; i++) begin
         logic [11:0] off;
         logic [15:0] e;
         logic [3:0]  b;
         e   = sw_entry(i);
         off = 12'((i * 91) % 4096);
         b   = 4'(i);
         @(negedge clk);
         acc_valid = 1'b1; acc_write = b[3];
         acc_addr  = {2'b00, 10'(i), off};
         cpu_addr  = 16'(i * 2);
         #1;
         chk("R2 phys", 32'(phys_addr), 32'({2'b00, e[9:0], off}));
         chk("R3 not_present", 32'(not_present), 32'(e[14:13] == 2'd0));
         @(negedge clk);
         acc_valid = 1'b0;
         #1;
         chk("R4 R5 R6 status after", 32'(cpu_rdata), 32'(sw_after(i)));
      end

      // R1: pass-through, no descriptor touched
      acc_write = 1'b1;
      @(negedge clk); acc_valid = 1'b1; acc_addr = 24'h4051A4; #1;
      chk("R1 phys 4051A4", 32'(phys_addr), 32'h4051A4);
      chk("R1 np 4051A4", 32'(not_present), 32'h0);
      @(negedge clk); acc_addr = 24'hFFFFFF; #1;
      chk("R1 phys FFFFFF", 32'(phys_addr), 32'hFFFFFF);
      @(negedge clk); acc_addr = 24'h800123; #1;
      chk("R1 phys 800123", 32'(phys_addr), 32'h800123);
      @(negedge clk); acc_valid = 1'b0;
      peek(16'h000A, v); chk("R1 entry5 kept", 32'(v), 32'(sw_after(5)));
      peek(16'h07FE, v); chk("R1 entry1023 kept", 32'(v), 32'(sw_after(1023)));
      peek(16'h0000, v); chk("R1 entry0 kept", 32'(v), 32'(sw_after(0)));

      // R12: idle strobe with a write flag changes nothing
      cpu_put(16'h0016, 1'b1, 16'h2033);
      @(negedge clk); acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 24'h00B000;
      @(negedge clk);
      peek(16'h0016, v); chk("R12 idle unchanged", 32'(v), 32'h2033);

      // R8: byte lanes
      cpu_put(16'h000E, 1'b1, 16'h0000);
      cpu_put(16'h000E, 1'b0, 16'h77A5);
      peek(16'h000E, v); chk("R8 even byte", 32'(v), 32'hA500);
      cpu_put(16'h000F, 1'b0, 16'h993C);
      peek(16'h000E, v); chk("R8 odd byte", 32'(v), 32'hA53C);

      // R9: mirror every 2 KB
      cpu_put(16'h080E, 1'b1, 16'h1234);
      peek(16'h000E, v); chk("R9 mirror write", 32'(v), 32'h1234);
      peek(16'hF80E, v); chk("R9 mirror read", 32'(v), 32'h1234);

      // R4 with neighbour port write, then R10 collision
      cpu_put(16'h0012, 1'b1, 16'h2011);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 24'h009000;
      cpu_wr = 1'b1; cpu_word = 1'b1; cpu_addr = 16'h0014; cpu_wdata = 16'h0055;
      @(negedge clk);
      acc_valid = 1'b0; cpu_wr = 1'b0;
      peek(16'h0012, v); chk("R4 read of fresh", 32'(v), 32'h4011);
      peek(16'h0014, v); chk("R7 neighbour write", 32'(v), 32'h0055);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 24'h009ABC;
      cpu_wr = 1'b1; cpu_word = 1'b1; cpu_addr = 16'h0012; cpu_wdata = 16'hA022;
      @(negedge clk);
      acc_valid = 1'b0; cpu_wr = 1'b0;
      peek(16'h0012, v); chk("R10 port wins", 32'(v), 32'hA022);

      summary();
      $finish;
   end
endmodule